// File: doc/BRIEF.md
# Bitmap Screen Column Address Generator

This block serves a drawing coprocessor that writes pixels into a planar bitmap held in RAM. The bitmap is stored as columns of character tiles. A configuration load captures three bytes: a screen mode byte, a screen base byte and a plot option byte. The block decodes them into a colour mode, a screen height and a byte size for the whole screen. It also works out the screen's base address and pulls that address down when the screen would run past the end of RAM.

A column lookup takes a 5-bit column index from 0 to 31. One cycle later the block returns two values: the byte address where that column starts, and an offset term that scales with the column. Both come from a cached layout snapshot, which holds the colour mode, the effective height code and the base. The snapshot is refreshed only when:
- the colour mode changes,
- the effective height changes, or
- the load marks the base byte as newly written.

If none of these holds, a changed base byte reaches the reported base but leaves the column results alone. A small controller sequences the work through three states:
- `ST_EMPTY`: after reset, no configuration loaded yet.
- `ST_EVAL`: one cycle after each load, in which geometry is evaluated and the snapshot may be refreshed.
- `ST_READY`: idle.

The transitions are:
- `ST_EMPTY` goes to `ST_EVAL` on a load.
- `ST_EVAL` goes to `ST_EVAL` on a further load, otherwise to `ST_READY`.
- `ST_READY` goes to `ST_EVAL` on a load.

Top module: `scr_col_gen`

## Requirements
- R1: The height code is {mode[5], mode[2]}. Code 0 selects 128 lines, code 1 selects 160, code 2 selects 192 and code 3 selects 256. Mode bits 3, 4, 6 and 7 have no effect.
- R2: mode[1:0] is the colour mode. Tiles are 16 bytes in colour mode 0, 32 bytes in colour mode 1 and 64 bytes in colour modes 2 and 3. For layout heights below 256, the column pointer is base + index × tile bytes.
- R3: For layout heights below 256, the column offset is index × (height/8) × tile bytes. Index 0 always gives offset 0.
- R4: At layout height 256, index bit 4 selects a half. With h = index[4], l = index[3:0] and tile bytes t, the pointer is base + h×512×t + l×16×t and the offset is h×256×t + l×t.
- R5: When the height code is 3, the screen size is 32768 bytes. Otherwise it is (height/8) × 32 × m, where m is 16, 32, 32 or 64 for colour modes 0 to 3.
- R6: Plot option bit 4 (object drawing) forces the layout height to 256. The reported size still uses the real height code.
- R7: The raw base is the base byte × 1024. If raw base + size exceeds RAM_BANKS × 65536, the reported base becomes RAM end − size. If the size alone exceeds RAM, the base becomes 0. Otherwise the raw base is kept, including the case where the screen ends exactly at RAM end.
- R8: The snapshot used for column results is refreshed on the first evaluation after reset, and afterwards only when the colour mode differs, the effective height code differs, or the load carried the base-written flag.
- R9: A lookup strobe produces out_valid, col_ptr and col_off on the next clock edge. out_valid is high for exactly one cycle per strobe.
- R10: Reset clears every output. The reset snapshot is colour mode 0, layout height 128 and base 0.
- R11: scr_size and scr_base update on the second clock edge after a load is sampled (the `ST_EVAL` cycle). A lookup taken during `ST_EVAL` uses the snapshot from before the load. When two loads come back to back, the later one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture the three configuration bytes |
| cfg_mode | input | 8 | Screen mode byte (colour mode, height code bits) |
| cfg_base | input | 8 | Screen base byte, in 1 KiB units |
| cfg_plot | input | 8 | Plot option byte; bit 4 selects object drawing |
| cfg_base_wr | input | 1 | With cfg_load: the base byte was written |
| lookup_valid | input | 1 | Column lookup strobe |
| lookup_idx | input | 5 | Column index 0..31 |
| out_valid | output | 1 | Lookup result valid |
| col_ptr | output | CALC_W | Column start byte address |
| col_off | output | 16 | Column offset term |
| scr_size | output | 17 | Screen size in bytes |
| scr_base | output | CALC_W | Clamped screen base address |

## Verification
The assertions check four rules on every cycle:
- out_valid pulses exactly once, one cycle after each lookup strobe.
- The reported base plus the size never passes RAM end.
- Index 0 always yields a zero offset.
- The geometry outputs hold still whenever no load was sampled in the two cycles before.

The bench scenarios cover what only concrete values can show:
- the height and colour decode, and the tile arithmetic;
- the split layout at 256 lines;
- object mode keeping the real size;
- the exact clamp boundary;
- the snapshot keeping a stale base until a mode change, a height change or a base write;
- the ordering of lookups and loads around the `ST_EVAL` cycle.

// File: rtl/scr_col_pkg.sv
package scr_col_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_EVAL  = 2'd1,
        ST_READY = 2'd2
    } cache_st_t;

    localparam int CMODE_W    = 2;
    localparam int HCODE_W    = 2;
    localparam int IDX_W      = 5;
    localparam int SIZE_W     = 17;
    localparam int OFF_W      = 16;
    localparam int BASE_SHIFT = 10;
    localparam int FULL_SIZE  = 32768;
    localparam int N_CMODES   = 1 << CMODE_W;

    // log2 of tile bytes per colour mode
    function automatic int unsigned tile_shift(input logic [CMODE_W-1:0] cm);
        unique case (cm)
            2'd0:    return 4;
            2'd1:    return 5;
            default: return 6;
        endcase
    endfunction

    // log2 of the size multiplier per colour mode
    function automatic int unsigned mult_shift(input logic [CMODE_W-1:0] cm);
        unique case (cm)
            2'd0:    return 4;
            2'd3:    return 6;
            default: return 5;
        endcase
    endfunction

    // tile rows (height / 8) per height code
    function automatic int unsigned tile_rows(input logic [HCODE_W-1:0] hc);
        unique case (hc)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/scr_mode_decode.sv
module scr_mode_decode
    import scr_col_pkg::*;
#(
    parameter int RAM_BANKS = 2,
    parameter int CALC_W    = 19
) (
    input  logic [7:0]          mode_reg,
    input  logic [7:0]          base_reg,
    input  logic                obj_mode,
    output logic [CMODE_W-1:0]  cmode,
    output logic [HCODE_W-1:0]  eff_code,
    output logic [SIZE_W-1:0]   size_c,
    output logic [CALC_W-1:0]   base_c
);
    localparam int RAM_BYTES = RAM_BANKS * 65536;
    localparam logic [CALC_W-1:0] RAM_END = CALC_W'(RAM_BYTES);

    logic [HCODE_W-1:0] real_code;
    logic [SIZE_W-1:0]  rows_v;
    logic [CALC_W-1:0]  base_raw;
    logic [CALC_W-1:0]  size_w;

    assign real_code = {mode_reg[5], mode_reg[2]};
    assign cmode     = mode_reg[CMODE_W-1:0];
    assign eff_code  = obj_mode ? 2'd3 : real_code;

    always_comb begin
        rows_v = SIZE_W'(tile_rows(real_code));
        if (real_code == 2'd3)
            size_c = SIZE_W'(FULL_SIZE);
        else
            size_c = rows_v << (5 + mult_shift(cmode));
    end

    always_comb begin
        base_raw = CALC_W'(base_reg) << BASE_SHIFT;
        size_w   = CALC_W'(size_c);
        if (size_w > RAM_END)
            base_c = '0;
        else if (base_raw + size_w > RAM_END)
            base_c = RAM_END - size_w;
        else
            base_c = base_raw;
    end

endmodule

// File: rtl/scr_col_calc.sv
module scr_col_calc
    import scr_col_pkg::*;
#(
    parameter int CALC_W = 19
) (
    input  logic [CALC_W-1:0]  base,
    input  logic [CMODE_W-1:0] cmode,
    input  logic [HCODE_W-1:0] eff_code,
    input  logic [IDX_W-1:0]   idx,
    output logic [CALC_W-1:0]  ptr,
    output logic [OFF_W-1:0]   off
);
    logic [CALC_W-1:0] cand_ptr [N_CMODES];
    logic [OFF_W-1:0]  cand_off [N_CMODES];

    logic       hi;
    logic [3:0] lo;
    assign hi = idx[IDX_W-1];
    assign lo = idx[3:0];

    for (genvar g = 0; g < N_CMODES; g++) begin : g_cm
        localparam int TS = int'(tile_shift(CMODE_W'(g)));

        logic [CALC_W-1:0] p_lin, p_split;
        logic [OFF_W-1:0]  o_lin, o_split;

        assign p_lin   = CALC_W'(idx) << TS;
        assign p_split = (CALC_W'(hi) << (TS + 9)) + (CALC_W'(lo) << (TS + 4));
        assign o_split = (OFF_W'(hi) << (TS + 8)) + (OFF_W'(lo) << TS);
        assign o_lin   = (OFF_W'(idx) << (TS + 4))
                       + ((eff_code == 2'd1) ? (OFF_W'(idx) << (TS + 2)) : '0)
                       + ((eff_code == 2'd2) ? (OFF_W'(idx) << (TS + 3)) : '0);

        assign cand_ptr[g] = (eff_code == 2'd3) ? p_split : p_lin;
        assign cand_off[g] = (eff_code == 2'd3) ? o_split : o_lin;
    end

    assign ptr = base + cand_ptr[cmode];
    assign off = cand_off[cmode];

endmodule

// File: rtl/scr_cache_ctrl.sv
module scr_cache_ctrl
    import scr_col_pkg::*;
#(
    parameter int CALC_W = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [7:0]          cfg_mode,
    input  logic [7:0]          cfg_base,
    input  logic [7:0]          cfg_plot,
    input  logic                cfg_base_wr,
    // captured configuration to the decoder
    output logic [7:0]          mode_q,
    output logic [7:0]          base_q,
    output logic                obj_q,
    // decoder results
    input  logic [CMODE_W-1:0]  dec_cmode,
    input  logic [HCODE_W-1:0]  dec_eff,
    input  logic [SIZE_W-1:0]   dec_size,
    input  logic [CALC_W-1:0]   dec_base,
    // snapshot and geometry
    output logic [CMODE_W-1:0]  snap_cmode,
    output logic [HCODE_W-1:0]  snap_eff,
    output logic [CALC_W-1:0]   snap_base,
    output logic [SIZE_W-1:0]   scr_size,
    output logic [CALC_W-1:0]   scr_base
);
    cache_st_t state, state_nx;
    logic      dirty;
    logic      snap_ok;
    logic      refresh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (cfg_load) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = cfg_load ? ST_EVAL : ST_READY;
            ST_READY: if (cfg_load) state_nx = ST_EVAL;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    assign refresh = (state == ST_EVAL) &&
                     (!snap_ok || dirty ||
                      (dec_cmode != snap_cmode) || (dec_eff != snap_eff));

    // outputs and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            base_q     <= '0;
            obj_q      <= 1'b0;
            dirty      <= 1'b0;
            snap_ok    <= 1'b0;
            snap_cmode <= '0;
            snap_eff   <= '0;
            snap_base  <= '0;
            scr_size   <= '0;
            scr_base   <= '0;
        end else begin
            if (cfg_load) begin
                mode_q <= cfg_mode;
                base_q <= cfg_base;
                obj_q  <= cfg_plot[4];
            end
            if (cfg_load && cfg_base_wr)
                dirty <= 1'b1;
            else if (state == ST_EVAL)
                dirty <= 1'b0;
            if (state == ST_EVAL) begin
                scr_size <= dec_size;
                scr_base <= dec_base;
            end
            if (refresh) begin
                snap_ok    <= 1'b1;
                snap_cmode <= dec_cmode;
                snap_eff   <= dec_eff;
                snap_base  <= dec_base;
            end
        end
    end

endmodule

// File: rtl/scr_col_gen.sv
module scr_col_gen
    import scr_col_pkg::*;
#(
    parameter  int RAM_BANKS = 2,
    localparam int RAM_W     = $clog2(RAM_BANKS * 65536 + 1),
    localparam int CALC_W    = ((RAM_W > 18) ? RAM_W : 18) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [7:0]        cfg_mode,
    input  logic [7:0]        cfg_base,
    input  logic [7:0]        cfg_plot,
    input  logic              cfg_base_wr,
    input  logic              lookup_valid,
    input  logic [4:0]        lookup_idx,
    output logic              out_valid,
    output logic [CALC_W-1:0] col_ptr,
    output logic [15:0]       col_off,
    output logic [16:0]       scr_size,
    output logic [CALC_W-1:0] scr_base
);
    logic [7:0]         mode_q, base_q;
    logic               obj_q;
    logic [CMODE_W-1:0] dec_cmode, snap_cmode;
    logic [HCODE_W-1:0] dec_eff, snap_eff;
    logic [SIZE_W-1:0]  dec_size;
    logic [CALC_W-1:0]  dec_base, snap_base;
    logic [CALC_W-1:0]  ptr_c;
    logic [OFF_W-1:0]   off_c;

    scr_cache_ctrl #(.CALC_W(CALC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_mode   (cfg_mode),
        .cfg_base   (cfg_base),
        .cfg_plot   (cfg_plot),
        .cfg_base_wr(cfg_base_wr),
        .mode_q     (mode_q),
        .base_q     (base_q),
        .obj_q      (obj_q),
        .dec_cmode  (dec_cmode),
        .dec_eff    (dec_eff),
        .dec_size   (dec_size),
        .dec_base   (dec_base),
        .snap_cmode (snap_cmode),
        .snap_eff   (snap_eff),
        .snap_base  (snap_base),
        .scr_size   (scr_size),
        .scr_base   (scr_base)
    );

    scr_mode_decode #(.RAM_BANKS(RAM_BANKS), .CALC_W(CALC_W)) u_dec (
        .mode_reg(mode_q),
        .base_reg(base_q),
        .obj_mode(obj_q),
        .cmode   (dec_cmode),
        .eff_code(dec_eff),
        .size_c  (dec_size),
        .base_c  (dec_base)
    );

    scr_col_calc #(.CALC_W(CALC_W)) u_calc (
        .base    (snap_base),
        .cmode   (snap_cmode),
        .eff_code(snap_eff),
        .idx     (lookup_idx),
        .ptr     (ptr_c),
        .off     (off_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            col_ptr   <= '0;
            col_off   <= '0;
        end else begin
            out_valid <= lookup_valid;
            if (lookup_valid) begin
                col_ptr <= ptr_c;
                col_off <= off_c;
            end
        end
    end

endmodule

// File: rtl/scr_col_gen_chk.sv
module scr_col_gen_chk #(
    parameter int RAM_BANKS = 2,
    parameter int CALC_W    = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              lookup_valid,
    input logic [4:0]        lookup_idx,
    input logic              out_valid,
    input logic [15:0]       col_off,
    input logic [16:0]       scr_size,
    input logic [CALC_W-1:0] scr_base
);
    localparam int RAM_BYTES = RAM_BANKS * 65536;

    assert_lookup_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> out_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !out_valid);

    assert_fit_in_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(scr_base) + int'(scr_size)) <= RAM_BYTES);

    assert_origin_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_idx == 5'd0) |=> (col_off == 16'd0));

    assert_geom_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load ##1 !cfg_load) |=> ($stable(scr_size) && $stable(scr_base)));

endmodule

bind scr_col_gen scr_col_gen_chk #(.RAM_BANKS(RAM_BANKS), .CALC_W(CALC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .lookup_valid(lookup_valid),
    .lookup_idx  (lookup_idx),
    .out_valid   (out_valid),
    .col_off     (col_off),
    .scr_size    (scr_size),
    .scr_base    (scr_base)
);

// File: tb/tb_scr_col_gen.sv
module tb_scr_col_gen;
    localparam int CLK_PERIOD = 10;
    localparam int RB         = 2;
    localparam int RAM_BYTES  = RB * 65536;
    localparam int RW         = $clog2(RAM_BYTES + 1);
    localparam int CW         = ((RW > 18) ? RW : 18) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [7:0]    cfg_mode = '0, cfg_base = '0, cfg_plot = '0;
    logic          cfg_base_wr = 1'b0;
    logic          lookup_valid = 1'b0;
    logic [4:0]    lookup_idx = '0;
    logic          out_valid;
    logic [CW-1:0] col_ptr, scr_base;
    logic [15:0]   col_off;
    logic [16:0]   scr_size;

    int total = 0, bad = 0;
    bit done = 0;
    int m_cm = 0, m_ec = 0, m_base = 0;
    bit m_ok = 0;
    int e_size = 0, e_base = 0;

    scr_col_gen #(.RAM_BANKS(RB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_base(cfg_base), .cfg_plot(cfg_plot), .cfg_base_wr(cfg_base_wr),
        .lookup_valid(lookup_valid), .lookup_idx(lookup_idx), .out_valid(out_valid),
        .col_ptr(col_ptr), .col_off(col_off), .scr_size(scr_size), .scr_base(scr_base)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tile_f(int cm);
        return (cm == 0) ? 16 : (cm == 1) ? 32 : 64;
    endfunction
    function automatic int rows_f(int hc);
        return (hc == 0) ? 16 : (hc == 1) ? 20 : (hc == 2) ? 24 : 32;
    endfunction
    function automatic int size_f(int cm, int hc);
        int mult;
        mult = (cm == 0) ? 16 : (cm == 3) ? 64 : 32;
        return (hc == 3) ? 32768 : rows_f(hc) * 32 * mult;
    endfunction
    function automatic int base_f(int scbr, int size);
        int b;
        b = scbr * 1024;
        if (size > RAM_BYTES) return 0;
        if (b + size > RAM_BYTES) return RAM_BYTES - size;
        return b;
    endfunction
    function automatic int ptr_f(int base, int cm, int ec, int i);
        int t;
        t = tile_f(cm);
        if (ec != 3) return base + i * t;
        return base + (i / 16) * 512 * t + (i % 16) * 16 * t;
    endfunction
    function automatic int off_f(int cm, int ec, int i);
        int t;
        t = tile_f(cm);
        if (ec != 3) return i * rows_f(ec) * t;
        return (i / 16) * 256 * t + (i % 16) * t;
    endfunction

    // snapshot model per R8
    task automatic model_update(int cm, int hc, int scbr, bit obj, bit wr);
        int ec;
        ec     = obj ? 3 : hc;
        e_size = size_f(cm, hc);
        e_base = base_f(scbr, e_size);
        if (!m_ok || wr || cm != m_cm || ec != m_ec) begin
            m_ok = 1; m_cm = cm; m_ec = ec; m_base = e_base;
        end
    endtask

    task automatic drive_cfg(int cm, int hc, int scbr, bit obj, bit wr);
        cfg_load    = 1'b1;
        // bits 3, 4, 6 and 7 set to show they are ignored (R1)
        cfg_mode    = 8'(cm | ((hc & 1) << 2) | ((hc >> 1) << 5) | 8'hD8);
        cfg_base    = 8'(scbr);
        cfg_plot    = obj ? 8'h10 : 8'h0F;
        cfg_base_wr = wr;
    endtask

    task automatic apply_cfg(int cm, int hc, int scbr, bit obj, bit wr);
        @(negedge clk);
        drive_cfg(cm, hc, scbr, obj, wr);
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_base_wr = 1'b0;
        @(negedge clk);
        model_update(cm, hc, scbr, obj, wr);
    endtask

    task automatic check_geom(input string tag);
        chk({tag, " size"}, int'(scr_size), e_size);
        chk({tag, " base"}, int'(scr_base), e_base);
    endtask

    task automatic probe(input string tag, input int idx);
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_idx   = 5'(idx);
        @(negedge clk);
        lookup_valid = 1'b0;
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " ptr"}, int'(col_ptr), ptr_f(m_base, m_cm, m_ec, idx));
        chk({tag, " off"}, int'(col_off), off_f(m_cm, m_ec, idx));
    endtask

    task automatic t_reset_R10;
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 col_ptr", int'(col_ptr), 0);
        chk("R10 col_off", int'(col_off), 0);
        chk("R10 scr_size", int'(scr_size), 0);
        chk("R10 scr_base", int'(scr_base), 0);
        probe("R10 reset snapshot", 5);
        @(negedge clk);
        chk("R9 single pulse", int'(out_valid), 0);
    endtask

    task automatic t_linear_R1_R2_R3;
        for (int hc = 0; hc < 3; hc++)
            for (int cm = 0; cm < 4; cm++) begin
                apply_cfg(cm, hc, 8'h08, 1'b0, 1'b1);
                check_geom("R1 R5 R7");
                probe("R2 R3", 7);
                probe("R2 R3", 31);
                probe("R3 index zero", 0);
            end
    endtask

    task automatic t_split_R4;
        for (int cm = 0; cm < 4; cm++) begin
            apply_cfg(cm, 3, 8'h04, 1'b0, 1'b1);
            check_geom("R4 R5");
            probe("R4 low half", 15);
            probe("R4 high half", 16);
            probe("R4 mixed", 27);
        end
    endtask

    task automatic t_objmode_R6;
        apply_cfg(1, 1, 8'h02, 1'b1, 1'b1);
        chk("R6 real size", int'(scr_size), 20 * 32 * 32);
        probe("R6 forced split", 19);
        apply_cfg(2, 0, 8'h02, 1'b1, 1'b1);
        chk("R6 real size", int'(scr_size), 16 * 32 * 32);
        probe("R6 forced split", 31);
    endtask

    task automatic t_clamp_R7;
        apply_cfg(0, 0, 8'h7F, 1'b0, 1'b1);
        chk("R7 clamped", int'(scr_base), RAM_BYTES - 8192);
        probe("R7 clamped ptr", 2);
        apply_cfg(0, 0, 8'h78, 1'b0, 1'b1);
        chk("R7 exact fit", int'(scr_base), 8'h78 * 1024);
        apply_cfg(3, 2, 8'hFF, 1'b0, 1'b1);
        chk("R7 clamp large", int'(scr_base), RAM_BYTES - 49152);
    endtask

    task automatic t_cache_R8;
        apply_cfg(1, 0, 8'h10, 1'b0, 1'b1);
        probe("R8 fresh", 3);
        apply_cfg(1, 0, 8'h20, 1'b0, 1'b0);
        chk("R8 base reported", int'(scr_base), 8'h20 * 1024);
        chk("R8 stale base kept", m_base, 8'h10 * 1024);
        probe("R8 stale ptr", 3);
        apply_cfg(1, 0, 8'h20, 1'b1, 1'b0);
        probe("R8 height change refresh", 3);
        apply_cfg(1, 0, 8'h30, 1'b1, 1'b0);
        probe("R8 no change stale", 4);
        apply_cfg(2, 0, 8'h30, 1'b1, 1'b0);
        probe("R8 mode change refresh", 4);
        apply_cfg(2, 0, 8'h08, 1'b1, 1'b1);
        probe("R8 base write refresh", 4);
    endtask

    task automatic t_fsm_R11;
        int old_base;
        apply_cfg(1, 0, 8'h10, 1'b0, 1'b1);
        old_base = m_base;
        @(negedge clk);
        drive_cfg(1, 0, 8'h30, 1'b0, 1'b1);
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_base_wr = 1'b0;
        lookup_valid = 1'b1;
        lookup_idx = 5'd3;
        chk("R11 size before eval", int'(scr_size), e_size);
        @(negedge clk);
        lookup_valid = 1'b0;
        chk("R11 lookup in eval", int'(col_ptr), old_base + 3 * 32);
        model_update(1, 0, 8'h30, 1'b0, 1'b1);
        check_geom("R11 after eval");
        probe("R11 refreshed", 3);
        // back-to-back loads: the later wins
        @(negedge clk);
        drive_cfg(0, 0, 8'h04, 1'b0, 1'b1);
        @(negedge clk);
        drive_cfg(3, 2, 8'h02, 1'b0, 1'b0);
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_base_wr = 1'b0;
        @(negedge clk);
        model_update(0, 0, 8'h04, 1'b0, 1'b1);
        model_update(3, 2, 8'h02, 1'b0, 1'b0);
        check_geom("R11 back to back");
        probe("R11 back to back", 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R10;
        t_linear_R1_R2_R3;
        t_split_R4;
        t_objmode_R6;
        t_clamp_R7;
        t_cache_R8;
        t_fsm_R11;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule